// File: doc/BRIEF.md
# Erasable One-Time-Write Byte Memory Model

This block is a clock-driven functional model of a byte-wide memory that behaves like an ultraviolet-erasable read-only memory. A host drives two active-low strobes (chip select and output gate), an address and a byte of write data. Two digital flags stand in for analog conditions: one for the raised programming supply, and one for the raised voltage on address line 9. The combination of strobes and flags picks one of several modes. Depending on the mode, the block drives stored data, drives a fixed identifier byte, releases the bus, or writes the presented byte into the array.

Stored bits can only move from 1 to 0 when written. The only way back to 1 is a separate erase input, which sets every bit of the array to 1 at one clock edge. Read data comes out through a registered path with a latency counted in clock cycles. Until that latency has elapsed after the address or mode changes, the output carries a fixed invalid marker. The default array is 1024 bytes; setting `ADDR_W` to 15 gives the full 32K arrangement.

Top module: `eprom_model`

## Requirements
- R1: After reset every byte reads as 8'hFF and the data bus is not driven (`dq_oe` = 0).
- R2: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `a9_hv`=0, `dq_oe` is 1 and `dq_out` carries the byte at `addr`. That byte is present after the LAT-th rising edge following the edge that first sees the new access.
- R3: With `ce_n`=1 and `vpp_hi`=0, `dq_oe` is 0 whatever `oe_n` is, and no byte is written.
- R4: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0, `dq_oe` is 0 and no byte is written.
- R5: With `vpp_hi`=1, `ce_n`=0 and `oe_n`=1, each rising edge writes `dq_in` into the byte at `addr`, and `dq_oe` is 0.
- R6: A write stores the bitwise AND of the old byte and `dq_in`, so no bit goes from 0 to 1.
- R7: `erase`=1 at a rising edge sets every byte to 8'hFF. It takes priority over a write in the same cycle.
- R8: With `vpp_hi`=1, `ce_n`=1 and `oe_n`=0, the stored byte at `addr` is driven as in R2.
- R9: With `vpp_hi`=1 and `oe_n`=1, `ce_n`=1 (or with `vpp_hi`=1, `ce_n`=0, `oe_n`=0), the bus is released and no byte is written.
- R10: With `a9_hv`=1 in the R2 strobe setting, `addr[0]`=0 returns 8'h97 and `addr[0]`=1 returns 8'h04, with the same latency as R2. The array is left unchanged.
- R11: Both identifier bytes have an odd number of ones; bit 7 is the parity bit.
- R12: While a driving access waits for its latency, `dq_out` shows INVALID_BYTE (default 8'h00, with HOLD_STALE=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| vpp_hi | input | 1 | Programming supply raised |
| a9_hv | input | 1 | Raised voltage on address line 9 (identifier access) |
| erase | input | 1 | Set whole array to ones |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Bus value presented to the block |
| dq_out | output | 8 | Bus value driven by the block |
| dq_oe | output | 1 | Block drives the bus |

## Verification
The bench goes after the corner cases of this block. It writes 1s over bytes that already hold 0s; a model that overwrote instead of ANDing would read the 1s back. It holds write data on the bus in the standby, disable and inhibit settings and then reads the byte back, which catches a write decode that is too loose. It reads with the strobes both low while the supply is raised, and it does an erase in the same cycle as a write, which exposes a wrong priority order. It checks both identifier bytes and their parity, and checks the invalid marker in every latency window, so an off-by-one in the counter shows up as early or late data.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    M_STANDBY   = 3'd0,
    M_READ      = 3'd1,
    M_DISABLE   = 3'd2,
    M_SIGNATURE = 3'd3,
    M_PROGRAM   = 3'd4,
    M_VERIFY    = 3'd5,
    M_INHIBIT   = 3'd6
  } mode_e;

  localparam int unsigned BYTE_W = 8;

  // Seven payload bits plus a top bit that makes the count of ones odd.
  function automatic logic [7:0] odd_par_byte(input logic [6:0] v);
    return {~^v, v};
  endfunction

endpackage

// File: rtl/eprom_rst_sync.sv
module eprom_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  vpp_hi,
  input  logic  a9_hv,
  output mode_e mode,
  output logic  drive,
  output logic  wr_en,
  output logic  sig_sel
);
  always_comb begin
    mode = M_STANDBY;
    unique case ({vpp_hi, ce_n, oe_n})
      3'b000: mode = a9_hv ? M_SIGNATURE : M_READ;
      3'b001: mode = M_DISABLE;
      3'b010: mode = M_STANDBY;
      3'b011: mode = M_STANDBY;
      3'b100: mode = M_INHIBIT;
      3'b101: mode = M_PROGRAM;
      3'b110: mode = M_VERIFY;
      3'b111: mode = M_INHIBIT;
      default: mode = M_STANDBY;
    endcase
  end

  always_comb begin
    drive   = (mode == M_READ) || (mode == M_SIGNATURE) || (mode == M_VERIFY);
    wr_en   = (mode == M_PROGRAM);
    sig_sel = (mode == M_SIGNATURE);
  end
endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    logic              hit;
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;
    logic              word_en;

    always_comb begin
      hit     = wr_en && (addr == ADDR_W'(gi));
      word_en = erase || hit;
      word_d  = erase ? {DATA_W{1'b1}} : (word_q & wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= {DATA_W{1'b1}};
      else if (word_en) word_q <= word_d;
    end

    assign words[gi] = word_q;
  end

  assign rdata = words[addr];

  // Capture of the write target, used only by the checks below.
  logic              chk_wr_q;
  logic              chk_ers_q;
  logic [ADDR_W-1:0] chk_addr_q;
  logic [DATA_W-1:0] chk_old_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_wr_q   <= 1'b0;
      chk_ers_q  <= 1'b0;
      chk_addr_q <= '0;
      chk_old_q  <= '0;
    end else begin
      chk_wr_q   <= wr_en;
      chk_ers_q  <= erase;
      chk_addr_q <= addr;
      chk_old_q  <= rdata;
    end
  end

  a_r6_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_wr_q && !chk_ers_q) |-> ((words[chk_addr_q] & ~chk_old_q) == '0));

  a_r7_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ers_q |-> (rdata == {DATA_W{1'b1}}));
endmodule

// File: rtl/eprom_rd_path.sv
module eprom_rd_path #(
  parameter int unsigned KEY_W        = 14,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned LAT          = 2,
  parameter bit          HOLD_STALE   = 1'b0,
  parameter logic [7:0]  INVALID_BYTE = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive,
  input  logic              is_sig,
  input  logic [KEY_W-1:0]  key,
  input  logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] data_out
);
  localparam int unsigned CW = $clog2(LAT) + 1;
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  logic [KEY_W-1:0]  key_q;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic              sig_q, sig_d;
  logic              same, valid_d;

  always_comb begin
    same    = drive && (key == key_q);
    cnt_d   = !same ? '0 : ((cnt_q == LAST) ? cnt_q : cnt_q + 1'b1);
    valid_d = drive && (cnt_d == LAST);
    if (valid_d)         out_d = src;
    else if (HOLD_STALE) out_d = out_q;
    else                 out_d = DATA_W'(INVALID_BYTE);
    sig_d   = valid_d && is_sig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
      cnt_q <= '0;
      out_q <= DATA_W'(INVALID_BYTE);
      sig_q <= 1'b0;
    end else begin
      key_q <= key;
      cnt_q <= cnt_d;
      out_q <= out_d;
      sig_q <= sig_d;
    end
  end

  assign data_out = out_q;

  a_r11_sig_parity: assert property (@(posedge clk) disable iff (!rst_n)
    sig_q |-> (^out_q == 1'b1));
endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int unsigned ADDR_W       = 10,
  parameter int unsigned LAT          = 2,
  parameter bit          HOLD_STALE   = 1'b0,
  parameter logic [7:0]  INVALID_BYTE = 8'h00,
  parameter logic [6:0]  MFG_ID7      = 7'h17,
  parameter logic [6:0]  DEV_ID7      = 7'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  localparam int unsigned KEY_W = ADDR_W + 4;
  localparam logic [7:0]  MFG_BYTE = odd_par_byte(MFG_ID7);
  localparam logic [7:0]  DEV_BYTE = odd_par_byte(DEV_ID7);

  logic        rst_sync_n;
  mode_e       mode;
  logic        drive, wr_en, sig_sel;
  logic [7:0]  arr_rdata;
  logic [7:0]  src;
  logic [KEY_W-1:0] key;

  eprom_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  eprom_mode_dec u_dec (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_hi  (vpp_hi),
    .a9_hv   (a9_hv),
    .mode    (mode),
    .drive   (drive),
    .wr_en   (wr_en),
    .sig_sel (sig_sel)
  );

  eprom_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_arr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .erase (erase),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (dq_in),
    .rdata (arr_rdata)
  );

  always_comb begin
    if (sig_sel) src = addr[0] ? DEV_BYTE : MFG_BYTE;
    else         src = arr_rdata;
    key = {mode, a9_hv, addr};
  end

  eprom_rd_path #(
    .KEY_W(KEY_W), .DATA_W(BYTE_W), .LAT(LAT),
    .HOLD_STALE(HOLD_STALE), .INVALID_BYTE(INVALID_BYTE)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .drive    (drive),
    .is_sig   (sig_sel),
    .key      (key),
    .src      (src),
    .data_out (dq_out)
  );

  assign dq_oe = drive;

  a_r3_standby_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ce_n && !vpp_hi) |-> (!dq_oe && !wr_en));

  a_r5_write_no_drive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> !dq_oe);

  a_r10_sig_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (a9_hv && !vpp_hi && !ce_n && !oe_n) |-> !wr_en);
endmodule

// File: tb/test_eprom_model.sv
module test_eprom_model;
  localparam int unsigned AW     = 10;
  localparam int unsigned LAT    = 2;
  localparam time         CLK_PER = 10ns;
  localparam logic [7:0]  INV    = 8'h00;

  logic clk, rst_n, ce_n, oe_n, vpp_hi, a9_hv, erase;
  logic [AW-1:0] addr;
  logic [7:0] dq_in, dq_out;
  logic dq_oe;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] mdl [1<<AW];

  typedef struct {
    int         due;
    bit         exp_oe;
    bit         chk_dat;
    logic [7:0] exp_dat;
    bit         par;
    string      req;
  } item_t;
  item_t sb[$];

  eprom_model #(.ADDR_W(AW), .LAT(LAT)) i_eprom_model (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .a9_hv(a9_hv), .erase(erase), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: compares scoreboard entries when they fall due.
  always @(negedge clk) begin
    item_t it;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      chk(dq_oe == it.exp_oe, {it.req, " oe"}, dq_oe, it.exp_oe);
      if (it.chk_dat) chk(dq_out == it.exp_dat, {it.req, " data"}, dq_out, it.exp_dat);
      if (it.par) chk(^dq_out == 1'b1, "R11 parity", ^dq_out, 1);
    end
  end

  task automatic park();
    ce_n = 1'b1; oe_n = 1'b1; vpp_hi = 1'b0; a9_hv = 1'b0; erase = 1'b0; dq_in = 8'hFF;
  endtask

  // Driver: one access, preceded by a standby cycle so the latency restarts.
  task automatic access(input bit ce, input bit oe, input bit vpp, input bit a9,
                        input logic [AW-1:0] a, input logic [7:0] din,
                        input bit exp_oe, input logic [7:0] exp, input bit par,
                        input string req);
    int c;
    @(negedge clk); park();
    @(negedge clk);
    ce_n = ce; oe_n = oe; vpp_hi = vpp; a9_hv = a9; addr = a; dq_in = din;
    c = cyc;
    if (exp_oe) begin
      for (int k = 1; k < LAT; k++) sb.push_back('{c + k, 1'b1, 1'b1, INV, 1'b0, "R12"});
      sb.push_back('{c + LAT, 1'b1, 1'b1, exp, par, req});
    end else begin
      sb.push_back('{c + 1, 1'b0, 1'b0, 8'h00, 1'b0, req});
    end
    repeat (LAT) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    access(1'b0, 1'b0, 1'b0, 1'b0, a, 8'hFF, 1'b1, mdl[a], 1'b0, req);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d, input bit with_erase);
    @(negedge clk); park();
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; vpp_hi = 1'b1; addr = a; dq_in = d; erase = with_erase;
    sb.push_back('{cyc + 1, 1'b0, 1'b0, 8'h00, 1'b0, "R5"});
    if (with_erase) foreach (mdl[i]) mdl[i] = 8'hFF;
    else            mdl[a] = mdl[a] & d;
    @(negedge clk); park();
  endtask

  task automatic do_erase();
    @(negedge clk); park(); erase = 1'b1;
    @(negedge clk); erase = 1'b0;
    foreach (mdl[i]) mdl[i] = 8'hFF;
  endtask

  initial begin
    foreach (mdl[i]) mdl[i] = 8'hFF;
    park(); addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dq_oe == 1'b0, "R1 reset oe", dq_oe, 0);

    rd(10'd0, "R1");
    rd(10'd1023, "R1");

    prog(10'd3, 8'h5A, 1'b0);
    rd(10'd3, "R5");
    prog(10'd3, 8'hF0, 1'b0);
    rd(10'd3, "R6");
    prog(10'd1023, 8'h00, 1'b0);
    rd(10'd1023, "R2");
    prog(10'd7, 8'hA5, 1'b0);
    rd(10'd7, "R2");

    access(1'b1, 1'b0, 1'b0, 1'b0, 10'd7, 8'h00, 1'b0, 8'h00, 1'b0, "R3");
    access(1'b1, 1'b1, 1'b0, 1'b0, 10'd7, 8'h00, 1'b0, 8'h00, 1'b0, "R3");
    rd(10'd7, "R3");

    access(1'b0, 1'b1, 1'b0, 1'b0, 10'd7, 8'h00, 1'b0, 8'h00, 1'b0, "R4");
    rd(10'd7, "R4");

    access(1'b1, 1'b0, 1'b1, 1'b0, 10'd3, 8'hFF, 1'b1, mdl[3], 1'b0, "R8");

    access(1'b1, 1'b1, 1'b1, 1'b0, 10'd7, 8'h00, 1'b0, 8'h00, 1'b0, "R9");
    access(1'b0, 1'b0, 1'b1, 1'b0, 10'd7, 8'h00, 1'b0, 8'h00, 1'b0, "R9");
    rd(10'd7, "R9");

    access(1'b0, 1'b0, 1'b0, 1'b1, 10'd0, 8'hFF, 1'b1, 8'h97, 1'b1, "R10 mfg");
    access(1'b0, 1'b0, 1'b0, 1'b1, 10'd1, 8'hFF, 1'b1, 8'h04, 1'b1, "R10 dev");
    rd(10'd0, "R10");
    rd(10'd3, "R10");

    do_erase();
    rd(10'd3, "R7");
    rd(10'd1023, "R7");
    prog(10'd5, 8'h0F, 1'b0);
    rd(10'd5, "R6");
    prog(10'd5, 8'h00, 1'b1);
    rd(10'd5, "R7");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule